// File: doc/BRIEF.md
# Driver Fault Diagnostic and Interrupt Controller

This block runs fault diagnostics for two high-side output drivers and one thermal sensor. Software writes a 16-bit control word that holds the output enables, a mode bit (normal or test) and a diagnostic-start bit. When a diagnostic starts, the block watches the raw fault comparator inputs over a window measured in microsecond ticks. A fault is recorded only if it stays present for the whole window.

When the window ends, the block writes the result into an 8-bit diagnostic register. Only the fault bits that have meaning in the current mode are kept. If the new result differs from the stored one, the block pulls its active-low interrupt request low and starts a fresh window by itself. A read of the diagnostic register, done while no window is running, clears the start bit and releases the interrupt.

The enables for both drivers, the auxiliary linear regulator and the switching regulator come straight from the control word. They are all held off while the block is in reset.

Top module: `hsd_diag_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `stat_q`=0x0000, `diag_q`=0x00, `irq_n`=1 and all five enables are 0.
- R2: A control write with bit 1 (test mode) set stores bits 15..2 as 0, whatever was written, so every output enable reads 0.
- R3: In normal mode (bit 1 = 0), a write with bit 0 (start) set is accepted only if bits 14 and 13 are both 1. Otherwise bit 0 is stored as 0, no window starts, and `diag_q` is left unchanged.
- R4: Diagnostic result bits:
  - bit 7 is the mode.
  - bits 6, 5 and 4 are overcurrent, open load and short to supply for driver 1.
  - bits 3, 2 and 1 are the same three faults for driver 2.
  - bit 0 is the thermal warning.

  `flt_raw[6:0]` uses the same positions as bits 6..0. In normal mode only bits 6, 3 and 0 can be 1. In test mode only bits 5, 4, 2, 1 and 0 can be 1.
- R5: A fault bit is captured only if its `flt_raw` input is 1 in every clock cycle from the start cycle through the cycle that ends the window. The window ends on the `WIN_US`-th tick after the start. A single-cycle dropout cancels the capture.
- R6: At the end of a window, `irq_n` goes low if the result differs from the stored `diag_q`, whether bits rise or fall. If the result is equal, `irq_n` is not changed.
- R7: Raising the interrupt sets control bit 0 and starts a new window automatically. While `irq_n` is low, bit 0 stays 1.
- R8: A `rd_diag` pulse while no window is running and bit 0 is 1 clears bit 0 and sets `irq_n` to 1. A `rd_diag` pulse during a window has no effect.
- R9: Enables follow the stored control word and are forced to 0 while `rst_n` is low:
  - `reg2_en` = bit 15
  - `drv1_en` = bit 14
  - `drv2_en` = bit 13
  - `pwm_fsel` = bit 10
  - `pwm_en` = bit 9

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also forces enables off |
| tick_1us | input | 1 | One-cycle pulse per microsecond |
| wr_stat | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word to write |
| rd_diag | input | 1 | Diagnostic register read completed |
| flt_raw | input | 7 | Raw fault comparators, same positions as diag bits 6..0 |
| stat_q | output | 16 | Stored control word |
| diag_q | output | 8 | Diagnostic register |
| irq_n | output | 1 | Interrupt request, low = active (0 drives low, 1 = released) |
| drv1_en | output | 1 | Driver 1 enable |
| drv2_en | output | 1 | Driver 2 enable |
| reg2_en | output | 1 | Auxiliary linear regulator enable |
| pwm_en | output | 1 | Switching regulator enable |
| pwm_fsel | output | 1 | Switching frequency select, 1 = high |

## Verification
A wrong window counter or a wrong persistence mask cannot be seen while the window runs. It shows at the ports only on the clock edge that ends the window: `diag_q` takes a wrong value, or `irq_n` falls or fails to fall at that edge. A wrong start acceptance or a wrong mode masking shows on `stat_q` and the enables one cycle after the write. The bench keeps a cycle-by-cycle model, so any such deviation is reported on the first clock where it reaches a port.

// File: rtl/hsd_diag_ctrl.sv
module hsd_diag_ctrl #(
  parameter int WIN_US = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1us,
  input  logic        wr_stat,
  input  logic [15:0] wr_data,
  input  logic        rd_diag,
  input  logic [6:0]  flt_raw,
  output logic [15:0] stat_q,
  output logic [7:0]  diag_q,
  output logic        irq_n,
  output logic        drv1_en,
  output logic        drv2_en,
  output logic        reg2_en,
  output logic        pwm_en,
  output logic        pwm_fsel
);
  localparam int CW = $clog2(WIN_US + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_US - 1);
  localparam logic [6:0] NORM_MASK = 7'b1001001;
  localparam logic [6:0] TEST_MASK = 7'b0110111;

  logic [15:0]   stat;
  logic [7:0]    diag;
  logic          irq_act, busy;
  logic [CW-1:0] cnt;
  logic [6:0]    alive;

  wire [15:0] wmask    = wr_data[1] ? {14'b0, wr_data[1:0]} : wr_data;
  wire        start_ok = wmask[0] & (wmask[1] | (wmask[14] & wmask[13]));
  wire        win_end  = busy & tick_1us & (cnt == LAST);
  wire [7:0]  result   = {stat[1], alive & flt_raw & (stat[1] ? TEST_MASK : NORM_MASK)};
  wire        raise    = win_end & (result != diag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat    <= '0;
      diag    <= '0;
      irq_act <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      alive   <= '0;
    end else begin
      if (busy) begin
        alive <= alive & flt_raw;
        if (tick_1us) cnt <= cnt + 1'b1;
      end
      if (win_end) begin
        diag <= result;
        cnt  <= '0;
        if (raise) begin
          irq_act <= 1'b1;
          stat[0] <= 1'b1;
          alive   <= flt_raw;
        end else begin
          busy <= 1'b0;
        end
      end else if (rd_diag && !wr_stat && !busy && stat[0]) begin
        stat[0] <= 1'b0;
        irq_act <= 1'b0;
      end
      if (wr_stat) begin
        stat <= {wmask[15:1], start_ok | irq_act | raise};
        if (start_ok) begin
          busy  <= 1'b1;
          cnt   <= '0;
          alive <= flt_raw;
        end else if (!(irq_act | raise)) begin
          busy <= 1'b0;
          cnt  <= '0;
        end
      end
    end
  end

  assign stat_q   = stat;
  assign diag_q   = diag;
  assign irq_n    = ~irq_act;
  assign reg2_en  = rst_n & stat[15];
  assign drv1_en  = rst_n & stat[14];
  assign drv2_en  = rst_n & stat[13];
  assign pwm_fsel = rst_n & stat[10];
  assign pwm_en   = rst_n & stat[9];

  assert_test_mode_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[1] |-> (stat_q[15:2] == 14'b0 && !drv1_en && !drv2_en && !reg2_en && !pwm_en));

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CW'(WIN_US)));

  assert_change_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(diag_q) |-> !irq_n);

  assert_irq_holds_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> stat_q[0]);

  assert_release_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> ($past(rd_diag) && !stat_q[0]));

  always_comb begin
    if (!rst_n) assert_reset_off_R9: assert (!drv1_en && !drv2_en && !reg2_en && !pwm_en && !pwm_fsel);
  end
endmodule

// File: tb/sim_hsd_diag_ctrl.sv
module sim_hsd_diag_ctrl;
  localparam int WIN = 5;
  logic clk = 0, rst_n = 0, tick = 0, wr = 0, rd = 0;
  logic [15:0] wdat = 0;
  logic [6:0] flt = 0;
  logic [15:0] stat_q;
  logic [7:0] diag_q;
  logic irq_n, drv1_en, drv2_en, reg2_en, pwm_en, pwm_fsel;
  int errors = 0, checks = 0, tcnt = 0, cyc = 0;

  hsd_diag_ctrl #(.WIN_US(WIN)) u0 (.clk(clk), .rst_n(rst_n), .tick_1us(tick), .wr_stat(wr),
    .wr_data(wdat), .rd_diag(rd), .flt_raw(flt), .stat_q(stat_q), .diag_q(diag_q), .irq_n(irq_n),
    .drv1_en(drv1_en), .drv2_en(drv2_en), .reg2_en(reg2_en), .pwm_en(pwm_en), .pwm_fsel(pwm_fsel));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    #1;
    tcnt = tcnt + 1;
    tick = (tcnt % 4 == 3);
  end

  // behavioural reference
  int m_stat = 0, m_diag = 0, m_irq = 0, m_busy = 0, m_ticks = 0, m_alive = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_diag = 0; m_irq = 0; m_busy = 0; m_ticks = 0; m_alive = 0;
    end else begin
      int w, res, mask;
      bit ok, fin, up;
      fin = 0; up = 0;
      if (m_busy != 0) begin
        m_alive = m_alive & flt;
        if (tick) begin
          m_ticks = m_ticks + 1;
          if (m_ticks == WIN) fin = 1;
        end
      end
      if (fin) begin
        mask = ((m_stat & 2) != 0) ? 'h37 : 'h49;
        res = (((m_stat >> 1) & 1) << 7) | (m_alive & mask);
        m_ticks = 0;
        if (res != m_diag) begin
          up = 1; m_irq = 1; m_stat = m_stat | 1; m_alive = flt;
        end else m_busy = 0;
        m_diag = res;
      end else if (rd && !wr && m_busy == 0 && (m_stat & 1) != 0) begin
        m_stat = m_stat & 'hFFFE; m_irq = 0;
      end
      if (wr) begin
        w = wdat[1] ? (wdat & 3) : wdat;
        ok = (w & 1) != 0 && ((w & 2) != 0 || (w & 'h6000) == 'h6000);
        m_stat = (w & 'hFFFE) | ((ok || m_irq != 0) ? 1 : 0);
        if (ok) begin m_busy = 1; m_ticks = 0; m_alive = flt; end
        else if (m_irq == 0) begin m_busy = 0; m_ticks = 0; end
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    int en_exp;
    cyc++;
    chk("R4 diag model", diag_q, m_diag);
    chk("R7 stat model", stat_q, m_stat);
    chk("R6 irq model", irq_n, m_irq == 0 ? 1 : 0);
    en_exp = rst_n ? (((m_stat >> 15) & 1) << 4 | ((m_stat >> 14) & 1) << 3 | ((m_stat >> 13) & 1) << 2
             | ((m_stat >> 10) & 1) << 1 | ((m_stat >> 9) & 1)) : 0;
    chk("R9 enables model", {reg2_en, drv1_en, drv2_en, pwm_fsel, pwm_en}, en_exp);
  end

  task automatic write(input logic [15:0] d);
    @(negedge clk); #1; wdat = d; wr = 1;
    @(negedge clk); #1; wr = 0;
  endtask
  task automatic rdpulse();
    @(negedge clk); #1; rd = 1;
    @(negedge clk); #1; rd = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R1 reset stat", stat_q, 0);
    chk("R1 reset irq", irq_n, 1);
    chk("R9 reset enables", {drv1_en, drv2_en, reg2_en, pwm_en}, 0);
    @(negedge clk); #1; rst_n = 1;
    idle(2);
    chk("R1 after release diag", diag_q, 0);

    // normal start with both drivers on
    flt = 7'h41;
    write(16'hE201);
    rdpulse();
    chk("R8 read during window ignored", stat_q, 16'hE201);
    chk("R9 drv1 mapping", drv1_en, 1);
    chk("R9 pwm mapping", {pwm_en, pwm_fsel}, 2'b10);
    idle(60);
    chk("R4 normal result", diag_q, 8'h41);
    chk("R6 irq on change", irq_n, 0);
    chk("R7 start held", stat_q[0], 1);
    rdpulse(); idle(1);
    chk("R8 read clears start", stat_q, 16'hE200);
    chk("R8 irq released", irq_n, 1);

    // dropout cancels oc2
    flt = 7'h49;
    write(16'hE201);
    idle(8);
    #1; flt = 7'h41;
    @(negedge clk); #1; flt = 7'h49;
    idle(40);
    chk("R5 dropout cancels", diag_q, 8'h41);
    chk("R6 no change no irq", irq_n, 1);
    rdpulse();

    // start rejected without both drivers
    write(16'h2001);
    idle(40);
    chk("R3 start rejected", stat_q, 16'h2000);
    chk("R3 diag unchanged", diag_q, 8'h41);

    // test mode
    flt = 7'h63;
    write(16'hFFFF);
    idle(1);
    chk("R2 test forces off", stat_q, 16'h0003);
    chk("R2 enables off", {drv1_en, drv2_en, reg2_en, pwm_en, pwm_fsel}, 0);
    idle(60);
    chk("R4 test result", diag_q, 8'hA3);
    chk("R6 irq test", irq_n, 0);
    rdpulse(); idle(1);
    chk("R8 clear test", stat_q, 16'h0002);

    // falling faults also raise irq
    flt = 7'h00;
    write(16'h0003);
    idle(60);
    chk("R6 falling change", diag_q, 8'h80);
    chk("R6 irq falling", irq_n, 0);
    rdpulse();

    // reset forces enables off
    write(16'hE600);
    idle(1);
    chk("R9 fsel mapping", {reg2_en, pwm_fsel}, 2'b11);
    @(negedge clk); #1; rst_n = 0;
    idle(1);
    chk("R9 reset forces off", {drv1_en, drv2_en, reg2_en, pwm_en, pwm_fsel}, 0);
    chk("R1 reset clears", stat_q, 0);
    @(negedge clk); #1; rst_n = 1;
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule